// File: doc/BRIEF.md
# Protected GPIO Direction Register Bank

This block holds the direction setting of every general-purpose pin on the chip: fifteen ports, fourteen of eight pins and a last one of two pins. A direction bit of 0 makes its pin an input and a bit of 1 makes it an output. Each stored bit drives the output enable of the pin of the same index, so the pad logic sees the direction directly. The block sits on a simple byte-wide register bus. A bus access is one cycle with `bus_valid` high. Read data is combinational in that same cycle, and writes take effect at the clock edge that ends the access.

Three rules control writes. One port (port 9) is protected: a write to it lands only if it is the first bus access after the protect strobe `prot_set`. Any access in between consumes that one-shot unlock. While the chip runs an external memory bus, the pins that bus owns are named by a per-pin mask, and the direction bits of those pins cannot be changed. The upper ports (11 to 14) are reachable only while `upper_en` is high. While it is low they keep their contents, ignore writes and read as zero.

Top module: `gpio_dir_bank`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) every direction bit is 0, so `pin_oe` is all zero and every port reads 00h.
- R2: A write sets the direction byte of the addressed port. Bit b of port p drives `pin_oe[8*p+b]`, where 1 means output and 0 means input.
- R3: Port p (0 to 14) is located at byte address 03E2h + 4*(p/2) + (p mod 2), using integer division. A read of that address returns the stored byte in the same cycle.
- R4: Port 14 stores only bits 1:0. Bits 7:2 of a write to it are dropped, and those bits read as 0.
- R5: An address that matches no port reads 00h, and a write to it changes no direction bit.
- R6: A write to port 9 changes it only when the one-shot unlock is set. Otherwise the write is ignored.
- R7: A `prot_set` pulse sets the unlock. Any bus access, read or write to any address, clears it. When `prot_set` and an access fall in the same cycle, the access sees the old unlock and the unlock is set afterwards.
- R8: While `ext_bus_mode` is 1, a write leaves unchanged every bit whose `bus_pin_mask` bit is 1 (mask bit 8*p+b guards port p bit b) and updates the others. While `ext_bus_mode` is 0 the mask has no effect.
- R9: While `upper_en` is 0, ports 11 to 14 read 00h, writes to them are ignored, and their contents and `pin_oe` bits are kept. Once `upper_en` is 1 again they read back their earlier values.
- R10: `bus_rdata` is 00h in every cycle without a read access, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus access happens in this cycle |
| bus_write | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read access |
| prot_set | input | 1 | Strobe that sets the one-shot unlock for port 9 |
| upper_en | input | 1 | Gives access to ports 11 to 14 |
| ext_bus_mode | input | 1 | External memory bus active, so masked pins are frozen |
| bus_pin_mask | input | 114 | 1 marks a pin owned by the external bus |
| pin_oe | output | 114 | Per-pin output enable (the direction bits) |

## Verification
The hardest case to reach is the lifetime of the port 9 unlock. A stray read or a write to another address between the strobe and the protected write must cancel it, and a strobe that coincides with an access must survive that access. The bench reaches these cases with explicit sequences: strobe then protected write, strobe then a read elsewhere then the protected write, strobe then a write elsewhere, and a strobe raised in the same cycle as a read. A bench-side unlock flag and register image predict every outcome. Freezing and upper-port gating are exercised by sweeping all 32 addresses of the window under a fixed mask, first with the mode on and then with it off.

// File: rtl/gpio_dir_pkg.sv
// Shared constants and the address formula of the direction bank.
// Assumes byte addressing and two ports per 4-byte group.
package gpio_dir_pkg;
    localparam int unsigned BYTE_W = 8;

    // Byte address of port p relative to the base of the bank.
    function automatic int unsigned port_addr(input int unsigned base, input int unsigned p);
        return base + 4 * (p / 2) + (p % 2);
    endfunction
endpackage

// File: rtl/gpio_dir_decode.sv
// Address decoder: turns a byte address into one select line per port.
// Assumes the port addresses are distinct, so at most one select is high.
module gpio_dir_decode #(
    parameter int unsigned NPORT     = 15,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h03E2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORT-1:0]  sel,
    output logic              hit
);
    // One comparator per port against its computed address.
    for (genvar p = 0; p < NPORT; p++) begin : g_cmp
        localparam int unsigned PADDR = gpio_dir_pkg::port_addr(BASE_ADDR, p);
        assign sel[p] = (addr == ADDR_W'(PADDR));
    end

    // Any matching port marks the address as mapped.
    assign hit = |sel;
endmodule

// File: rtl/gpio_dir_unlock.sv
// One-shot write unlock for the protected port.
// Assumes arm and access are single-cycle qualified strobes.
module gpio_dir_unlock (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic access,
    output logic unlocked
);
    // Arm sets the flag; any access without a new arm clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       unlocked <= 1'b0;
        else if (arm)     unlocked <= 1'b1;
        else if (access)  unlocked <= 1'b0;
    end

    p_unlock_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !arm) |=> !unlocked);
    p_unlock_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> unlocked);
endmodule

// File: rtl/gpio_dir_port.sv
// Direction register of one port, W stored bits.
// Assumes the caller has already matched the address; freeze bits keep their old value.
module gpio_dir_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_wr,
    input  logic         acc_en,
    input  logic         wr_allow,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] freeze,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] dir_d;

    // Merge new data with the frozen bits.
    always_comb begin
        dir_d = (dir_q & freeze) | (wdata & ~freeze);
    end

    // Update on an accepted write; reset makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dir_q <= '0;
        else if (sel_wr && acc_en && wr_allow) dir_q <= dir_d;
    end

    p_frozen_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dir_q ^ $past(dir_q)) & $past(freeze)) == '0);
    p_gated_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(dir_q));
endmodule

// File: rtl/gpio_dir_bank.sv
// Top of the direction bank: decoder, unlock flag, one register per port,
// and the read multiplexer. Assumes one bus access per cycle with
// combinational read data. The last port is narrower than the others.
module gpio_dir_bank #(
    parameter int unsigned NPORT       = 15,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 32'h03E2,
    parameter int unsigned LAST_W      = 2,
    parameter int unsigned PROT_PORT   = 9,
    parameter int unsigned UPPER_FIRST = 11,
    localparam int unsigned BW         = gpio_dir_pkg::BYTE_W,
    localparam int unsigned PINS       = (NPORT - 1) * BW + LAST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic              prot_set,
    input  logic              upper_en,
    input  logic              ext_bus_mode,
    input  logic [PINS-1:0]   bus_pin_mask,
    output logic [PINS-1:0]   pin_oe
);
    logic [NPORT-1:0]         sel;
    logic                     hit;
    logic                     unlocked;
    logic [NPORT-1:0][BW-1:0] rd_lane;

    gpio_dir_decode #(
        .NPORT(NPORT), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(bus_addr), .sel(sel), .hit(hit)
    );

    gpio_dir_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .arm(prot_set),
        .access(bus_valid), .unlocked(unlocked)
    );

    // One register per port; width, gating and protection chosen per index.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int unsigned W   = (p == NPORT - 1) ? LAST_W : BW;
        localparam int unsigned LSB = p * BW;
        logic         acc_en;
        logic         wr_allow;
        logic [W-1:0] freeze;
        logic [W-1:0] dir_q;

        assign acc_en   = (p >= UPPER_FIRST) ? upper_en : 1'b1;
        assign wr_allow = (p == PROT_PORT) ? unlocked : 1'b1;
        assign freeze   = ext_bus_mode ? bus_pin_mask[LSB +: W] : '0;

        gpio_dir_port #(.W(W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .sel_wr(bus_valid && bus_write && sel[p]),
            .acc_en(acc_en), .wr_allow(wr_allow),
            .wdata(bus_wdata[W-1:0]), .freeze(freeze), .dir_q(dir_q)
        );

        assign pin_oe[LSB +: W] = dir_q;
        assign rd_lane[p]       = (sel[p] && acc_en) ? BW'(dir_q) : '0;
    end

    // Read multiplexer: OR of the lanes during a read access only.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            for (int p = 0; p < NPORT; p++) bus_rdata = bus_rdata | rd_lane[p];
        end
    end

    p_locked_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sel[PROT_PORT] && !unlocked)
        |=> $stable(pin_oe[PROT_PORT*BW +: BW]));
    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !hit) |-> bus_rdata == '0);
    p_unmapped_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !hit) |=> $stable(pin_oe));
    p_disabled_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !upper_en && (|sel[NPORT-1:UPPER_FIRST])) |-> bus_rdata == '0);
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || bus_write) |-> bus_rdata == '0);
endmodule

// File: tb/gpio_dir_bank_tb.sv
module gpio_dir_bank_tb;
    localparam int NP = 15;
    localparam int PINS = 114;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            prot_set = 1'b0;
    logic            upper_en = 1'b0;
    logic            ext_bus_mode = 1'b0;
    logic [PINS-1:0] bus_pin_mask = '0;
    logic [PINS-1:0] pin_oe;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   unl = 1'b0;
    logic [7:0] exp_dir [NP];

    always #2 clk = ~clk;

    gpio_dir_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_set(prot_set), .upper_en(upper_en), .ext_bus_mode(ext_bus_mode),
        .bus_pin_mask(bus_pin_mask), .pin_oe(pin_oe)
    );

    function automatic logic [15:0] addr_of(int p);
        return 16'(16'h03E2 + 4 * (p / 2) + (p % 2));
    endfunction

    function automatic int port_of(logic [15:0] a);
        for (int p = 0; p < NP; p++) if (addr_of(p) == a) return p;
        return -1;
    endfunction

    function automatic int width_of(int p);
        return (p == NP - 1) ? 2 : 8;
    endfunction

    function automatic logic [PINS-1:0] exp_oe();
        logic [PINS-1:0] v = '0;
        for (int p = 0; p < NP; p++)
            for (int b = 0; b < width_of(p); b++) v[p*8+b] = exp_dir[p][b];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        int p = port_of(a);
        if (p < 0) return 8'h00;
        if (p >= 11 && !upper_en) return 8'h00;
        return exp_dir[p];
    endfunction

    task automatic chk(string tag, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of an accepted write, from the requirements.
    task automatic model_write(logic [15:0] a, logic [7:0] d, bit unl_now);
        int p = port_of(a);
        logic [7:0] nv;
        if (p < 0) return;
        if (p >= 11 && !upper_en) return;
        if (p == 9 && !unl_now) return;
        nv = exp_dir[p];
        for (int b = 0; b < width_of(p); b++)
            if (!(ext_bus_mode && bus_pin_mask[p*8+b])) nv[b] = d[b];
        exp_dir[p] = nv;
    endtask

    // One bus access; read data checked before the closing edge.
    task automatic acc(bit wr, logic [15:0] a, logic [7:0] d, bit arm, string tag);
        bit u0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; prot_set = arm;
        #1;
        if (wr) chk("R10 rdata in write cycle", PINS'(bus_rdata), '0);
        else    chk(tag, PINS'(bus_rdata), PINS'(exp_read(a)));
        u0 = unl;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0; prot_set = 1'b0;
        if (wr) model_write(a, d, u0);
        unl = arm;
    endtask

    task automatic arm_only();
        @(negedge clk);
        prot_set = 1'b1;
        @(posedge clk);
        #1 prot_set = 1'b0;
        unl = 1'b1;
    endtask

    task automatic read_all(string tag);
        for (int a = 16'h03E0; a < 16'h0400; a++) begin
            int p = port_of(16'(a));
            if (p < 0)       acc(1'b0, 16'(a), 8'h00, 1'b0, {tag, " R5 unmapped read"});
            else if (p == 14) acc(1'b0, 16'(a), 8'h00, 1'b0, {tag, " R4 port 14 read"});
            else              acc(1'b0, 16'(a), 8'h00, 1'b0, {tag, " R3 mapped read"});
        end
        @(negedge clk);
        chk({tag, " R2 pin_oe"}, pin_oe, exp_oe());
    endtask

    task automatic write_sweep(int seed, bit arm9);
        for (int a = 16'h03E0; a < 16'h0400; a++) begin
            if (arm9 && port_of(16'(a)) == 9) arm_only();
            acc(1'b1, 16'(a), 8'((a * seed + 11) ^ (a >> 2)), 1'b0, "");
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) exp_dir[p] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, all lower ports and pins are inputs.
        @(negedge clk);
        chk("R1 pin_oe after reset", pin_oe, '0);
        read_all("R1");
        upper_en = 1'b1;
        read_all("R1 upper");

        // R2/R3/R4/R5: full address sweeps with two data patterns.
        write_sweep(37, 1'b0);
        read_all("R2 sweep A");
        write_sweep(91, 1'b0);
        read_all("R2 sweep B");
        acc(1'b1, addr_of(14), 8'hFF, 1'b0, "");
        acc(1'b0, addr_of(14), 8'h00, 1'b0, "R4 upper bits dropped");

        // R6: protected write with and without unlock.
        arm_only();
        acc(1'b1, addr_of(9), 8'hA5, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R6 unlocked write lands");
        acc(1'b1, addr_of(9), 8'h5A, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R6 locked write ignored");

        // R7: unlock consumed by a read, by a write elsewhere, and by an unmapped access.
        arm_only();
        acc(1'b0, addr_of(0), 8'h00, 1'b0, "R7 read consumes");
        acc(1'b1, addr_of(9), 8'h0F, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R7 unlock gone after read");
        arm_only();
        acc(1'b1, addr_of(3), 8'h81, 1'b0, "");
        acc(1'b1, addr_of(9), 8'hF0, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R7 unlock gone after write");
        arm_only();
        acc(1'b0, 16'h03E0, 8'h00, 1'b0, "R7 unmapped read consumes");
        acc(1'b1, addr_of(9), 8'h77, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R7 unlock gone after unmapped");
        // Strobe during a read: the read sees the old flag, the flag survives.
        acc(1'b0, addr_of(1), 8'h00, 1'b1, "R7 read with strobe");
        acc(1'b1, addr_of(9), 8'h3C, 1'b0, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R7 strobe with access arms");
        // Strobe during a write to port 9: old flag (clear), write dropped.
        acc(1'b1, addr_of(9), 8'hC3, 1'b1, "");
        acc(1'b0, addr_of(9), 8'h00, 1'b0, "R7 same-cycle strobe uses old flag");

        // R8: frozen pins in external-bus mode, then mask without effect.
        for (int i = 0; i < PINS; i++) bus_pin_mask[i] = ((i * 7 + 3) % 5) < 2;
        ext_bus_mode = 1'b1;
        write_sweep(53, 1'b1);
        read_all("R8 frozen");
        ext_bus_mode = 1'b0;
        write_sweep(29, 1'b1);
        read_all("R8 mode off");

        // R9: upper ports gated, retained, then visible again.
        upper_en = 1'b0;
        for (int p = 11; p < NP; p++) acc(1'b0, addr_of(p), 8'h00, 1'b0, "R9 disabled read zero");
        for (int p = 11; p < NP; p++) acc(1'b1, addr_of(p), ~exp_dir[p], 1'b0, "");
        acc(1'b1, addr_of(5), 8'h6E, 1'b0, "");
        @(negedge clk);
        chk("R9 pin_oe retained while disabled", pin_oe, exp_oe());
        acc(1'b0, addr_of(5), 8'h00, 1'b0, "R9 lower port writable while disabled");
        upper_en = 1'b1;
        for (int p = 11; p < NP; p++) acc(1'b0, addr_of(p), 8'h00, 1'b0, "R9 contents back");

        // R10: idle bus reads zero even with a mapped address present.
        @(negedge clk);
        bus_addr = addr_of(2);
        #1 chk("R10 idle rdata", PINS'(bus_rdata), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule